// File: doc/BRIEF.md
# Programmable Even Clock Divider

This block derives a slower processor clock rate from a free-running oscillator clock. A programmed 8-bit value N selects a division ratio of 2×N, so the slowest setting (N = 255) runs 510 times slower than the oscillator. N = 0 is not an illegal value: it selects pass-through, where every oscillator cycle counts.

The block never gates or muxes a real clock. It runs entirely in the oscillator domain. It presents a one-cycle clock-enable strobe `clk_en` that marks the end of each output period, and a level `clk_div` that traces the divided waveform at 50% duty. Software may rewrite the divisor at any moment. The new value is staged, and it becomes live only at the end of the output period in progress. As a result, no low or high phase of `clk_div` is ever cut short. The block also holds a low-power hint bit that software sets or clears and that any reset clears.

Top module: `clkdiv_even`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `div_prog`, `div_live`, `low_power` and `clk_div` are 0 and `clk_en` is 1.
- R2: With a live divisor N > 0, `clk_en` is 1 for exactly one cycle in every 2×N oscillator cycles.
- R3: With N > 0, each output period starts with N cycles of `clk_div` = 0, which begin in the cycle after a `clk_en` pulse, followed by N cycles of `clk_div` = 1. The `clk_en` pulse falls in the last high cycle.
- R4: With a live divisor of 0 (bypass), `clk_en` is 1 in every cycle and `clk_div` stays 0.
- R5: A divisor write (`div_wr` = 1) shows on `div_prog` in the next cycle. `div_live` keeps its old value until the cycle after the next `clk_en` pulse, so the period already in progress completes with its old length of 2×old.
- R6: Leaving bypass, a new nonzero divisor becomes live in the cycle after it appears on `div_prog`.
- R7: N = 255 gives a 510-cycle period with 255 high cycles.
- R8: `low_power` changes only through `lp_wr` and takes `lp_wdata` in the next cycle. Divisor writes leave `low_power` unchanged, and `low_power` writes leave `div_prog` unchanged.
- R9: A reset asserted at any time returns the block to the R1 state, clearing the low-power bit and returning to bypass.
- R10: Every low or high run of `clk_div` lasts exactly the live divisor value in force for that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 8 | Divisor value to stage |
| lp_wr | input | 1 | Low-power bit write strobe |
| lp_wdata | input | 1 | Low-power bit value |
| clk_en | output | 1 | One-cycle strobe at the end of each output period |
| clk_div | output | 1 | Divided waveform level, 50% duty |
| div_prog | output | 8 | Staged (programmed) divisor |
| div_live | output | 8 | Divisor currently in force |
| low_power | output | 1 | Low-power hint bit |

## Verification
The assertions assume that the write strobes are never raised in a cycle where `rst_n` is low. They also assume that reset is held for at least one full clock edge. Under those two conditions, the next-cycle update checks and the run-length counter in the checker start from a known state. The directed bench drives every input at the falling edge and raises strobes only after reset has been released for a cycle. It returns each strobe to 0 after a single cycle, so no write overlaps a reset edge.

// File: rtl/clkdiv_pkg.sv
// Shared definitions for the even clock divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package clkdiv_pkg;
    localparam int unsigned DIV_W_DEF = 8;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/clkdiv_cfg.sv
// Holds the staged divisor and the low-power hint bit written by software.
// Assumes: write strobes are single-cycle pulses in the oscillator domain;
// reset is synchronous and active low and clears both fields.
module clkdiv_cfg #(
    parameter int unsigned DIV_W = clkdiv_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             lp_wr,
    input  logic             lp_wdata,
    output logic [DIV_W-1:0] div_prog,
    output logic             low_power
);
    logic [DIV_W-1:0] prog_q;
    logic             lp_q;

    // Stage a new divisor on each divisor write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prog_q <= '0;
        else if (div_wr)
            prog_q <= div_wdata;
    end

    // Keep the low-power hint; only its own write port changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lp_q <= 1'b0;
        else if (lp_wr)
            lp_q <= lp_wdata;
    end

    assign div_prog  = prog_q;
    assign low_power = lp_q;
endmodule

// File: rtl/clkdiv_core.sv
// Period generator: counts oscillator cycles against the live divisor, traces
// a 50% waveform, and adopts the staged divisor only at a period boundary.
// Assumes: next_div may change in any cycle; a live value of 0 means bypass.
module clkdiv_core #(
    parameter int unsigned DIV_W = clkdiv_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] next_div,
    output logic [DIV_W-1:0] live_div,
    output logic             period_end,
    output logic             wave
);
    import clkdiv_pkg::*;

    logic [DIV_W-1:0] live_q;
    logic [DIV_W-1:0] cnt_q;
    phase_e           ph_q;
    logic             bypass;
    logic             last_cnt;

    // Decode the bypass setting and the last cycle of a half period.
    always_comb begin
        bypass     = (live_q == '0);
        last_cnt   = (cnt_q == live_q - DIV_W'(1));
        period_end = bypass || (ph_q == PH_HIGH && last_cnt);
    end

    // Advance the half-period counter and load the staged divisor at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            cnt_q  <= '0;
            ph_q   <= PH_LOW;
        end else if (period_end) begin
            live_q <= next_div;
            cnt_q  <= '0;
            ph_q   <= PH_LOW;
        end else if (last_cnt) begin
            cnt_q  <= '0;
            ph_q   <= PH_HIGH;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end

    assign live_div = live_q;
    assign wave     = (ph_q == PH_HIGH);
endmodule

// File: rtl/clkdiv_even.sv
// Top level of the even clock divider: register port plus period generator.
// Assumes: a single oscillator clock domain; outputs are a clock-enable strobe
// and a waveform level, never a gated clock.
module clkdiv_even #(
    parameter int unsigned DIV_W = clkdiv_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             lp_wr,
    input  logic             lp_wdata,
    output logic             clk_en,
    output logic             clk_div,
    output logic [DIV_W-1:0] div_prog,
    output logic [DIV_W-1:0] div_live,
    output logic             low_power
);
    logic [DIV_W-1:0] staged;

    clkdiv_cfg #(.DIV_W(DIV_W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .lp_wr     (lp_wr),
        .lp_wdata  (lp_wdata),
        .div_prog  (staged),
        .low_power (low_power)
    );

    clkdiv_core #(.DIV_W(DIV_W)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_div   (staged),
        .live_div   (div_live),
        .period_end (clk_en),
        .wave       (clk_div)
    );

    assign div_prog = staged;
endmodule

// File: rtl/clkdiv_even_chk.sv
// Property checker for clkdiv_even, attached by bind.
// Assumes: write strobes are never raised while reset is low.
module clkdiv_even_chk #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_wr,
    input logic [DIV_W-1:0] div_wdata,
    input logic             lp_wr,
    input logic             lp_wdata,
    input logic             clk_en,
    input logic             clk_div,
    input logic [DIV_W-1:0] div_prog,
    input logic [DIV_W-1:0] div_live,
    input logic             low_power
);
    logic [DIV_W:0] run_q;
    logic           wave_q;

    // Length of the current clk_div run while a nonzero divisor is live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            wave_q <= 1'b0;
        end else begin
            wave_q <= clk_div;
            if (div_live == '0)
                run_q <= '0;
            else if (clk_div != wave_q)
                run_q <= (DIV_W+1)'(1);
            else
                run_q <= run_q + (DIV_W+1)'(1);
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (div_prog == '0 && div_live == '0 && !low_power && clk_en && !clk_div));

    assert_bypass_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_div |-> div_live != '0);

    assert_stage_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> div_prog == $past(div_wdata));

    assert_live_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_live) |-> $past(clk_en));

    assert_lp_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lp_wr |=> low_power == $past(lp_wdata));

    assert_lp_only_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(low_power) |-> $past(lp_wr));

    assert_low_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_div) |-> run_q == {1'b0, div_live});

    assert_high_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_div) |-> run_q == {1'b0, $past(div_live)});
endmodule

bind clkdiv_even clkdiv_even_chk #(.DIV_W(DIV_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_wr    (div_wr),
    .div_wdata (div_wdata),
    .lp_wr     (lp_wr),
    .lp_wdata  (lp_wdata),
    .clk_en    (clk_en),
    .clk_div   (clk_div),
    .div_prog  (div_prog),
    .div_live  (div_live),
    .low_power (low_power)
);

// File: tb/test_clkdiv_even.sv
// Directed bench for clkdiv_even: one task per scenario, each self-checking.
module test_clkdiv_even;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_wr = 1'b0;
    logic [7:0] div_wdata = '0;
    logic       lp_wr = 1'b0;
    logic       lp_wdata = 1'b0;
    logic       clk_en;
    logic       clk_div;
    logic [7:0] div_prog;
    logic [7:0] div_live;
    logic       low_power;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    clkdiv_even i_clkdiv_even (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .lp_wr     (lp_wr),
        .lp_wdata  (lp_wdata),
        .clk_en    (clk_en),
        .clk_div   (clk_div),
        .div_prog  (div_prog),
        .div_live  (div_live),
        .low_power (low_power)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_div(input logic [7:0] v);
        div_wr = 1'b1; div_wdata = v;
        tick();
        div_wr = 1'b0;
    endtask

    task automatic write_lp(input logic v);
        lp_wr = 1'b1; lp_wdata = v;
        tick();
        lp_wr = 1'b0;
    endtask

    task automatic sync_strobe();
        int g = 0;
        while (!clk_en && g < 2000) begin tick(); g++; end
    endtask

    // Counts the cycles after a strobe up to and including the next strobe.
    task automatic run_period(output int len, output int hi, output int first);
        len = 0; hi = 0; first = -1;
        do begin
            tick();
            len++;
            if (len == 1) first = int'(clk_div);
            if (clk_div) hi++;
        end while (!clk_en && len < 1000);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(div_prog == 0 && div_live == 0, "R1 divisors in reset", int'(div_live), 0);
            chk(!low_power && !clk_div, "R1 lp/clk_div in reset", int'(low_power), 0);
            chk(clk_en, "R1 strobe in reset", int'(clk_en), 1);
        end
        rst_n = 1'b1;
        tick();
        chk(div_live == 0 && clk_en && !clk_div, "R1 after release", int'(clk_en), 1);
    endtask

    task automatic t_bypass();
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(clk_en && !clk_div, "R4 bypass every cycle", int'(clk_en), 1);
        end
    endtask

    task automatic t_divide(input int n, input string req);
        int len, hi, first;
        write_div(8'(n));
        sync_strobe();
        run_period(len, hi, first);
        chk(len == 2 * n, {req, " R2 period"}, len, 2 * n);
        chk(hi == n, {req, " R3 high cycles"}, hi, n);
        chk(first == 0, {req, " R3 starts low"}, first, 0);
        chk(div_live == 8'(n), {req, " live divisor"}, int'(div_live), n);
        run_period(len, hi, first);
        chk(len == 2 * n, {req, " R2 repeat period"}, len, 2 * n);
    endtask

    // Changes the divisor mid-period and checks that the current period completes.
    task automatic t_change(input int old_n, input int new_n);
        int len, hi, first;
        sync_strobe();
        len = 0;
        tick(); len++;
        div_wr = 1'b1; div_wdata = 8'(new_n);
        tick(); len++;
        div_wr = 1'b0;
        chk(div_prog == 8'(new_n), "R5 staged next cycle", int'(div_prog), new_n);
        chk(div_live == 8'(old_n), "R5 live unchanged mid-period", int'(div_live), old_n);
        while (!clk_en && len < 1000) begin tick(); len++; end
        chk(len == 2 * old_n, "R5 old period completes", len, 2 * old_n);
        run_period(len, hi, first);
        chk(div_live == 8'(new_n), "R5 live after boundary", int'(div_live), new_n);
        if (new_n == 0)
            chk(len == 1 && hi == 0, "R4 bypass after switch", len, 1);
        else
            chk(len == 2 * new_n && hi == new_n, "R5 new period", len, 2 * new_n);
    endtask

    task automatic t_leave_bypass();
        write_div(8'd4);
        chk(div_live == 0, "R6 still bypass this cycle", int'(div_live), 0);
        tick();
        chk(div_live == 8'd4, "R6 live next cycle", int'(div_live), 4);
        chk(!clk_div && !clk_en, "R6 first divided cycle low", int'(clk_en), 0);
    endtask

    task automatic t_low_power();
        chk(!low_power, "R8 lp starts clear", int'(low_power), 0);
        write_lp(1'b1);
        chk(low_power, "R8 lp set", int'(low_power), 1);
        chk(div_prog == 8'd4, "R8 lp write keeps divisor", int'(div_prog), 4);
        write_div(8'd7);
        chk(low_power, "R8 divisor write keeps lp", int'(low_power), 1);
        write_lp(1'b0);
        chk(!low_power, "R8 lp clear", int'(low_power), 0);
        chk(div_prog == 8'd7, "R8 divisor kept", int'(div_prog), 7);
        write_lp(1'b1);
    endtask

    task automatic t_mid_reset();
        write_div(8'd5);
        repeat (13) tick();
        rst_n = 1'b0;
        tick();
        chk(div_prog == 0 && div_live == 0, "R9 divisors cleared", int'(div_prog), 0);
        chk(!low_power, "R9 lp cleared", int'(low_power), 0);
        chk(clk_en && !clk_div, "R9 bypass in reset", int'(clk_en), 1);
        tick();
        rst_n = 1'b1;
        tick();
        chk(clk_en && !clk_div && div_live == 0, "R9 bypass after reset", int'(div_live), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog all actual=150000 expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_bypass();
        t_divide(1, "N1");
        t_divide(3, "N3");
        t_divide(255, "R7 N255");
        t_divide(3, "N3b");
        t_change(3, 5);
        t_change(5, 0);
        t_bypass();
        t_leave_bypass();
        t_low_power();
        t_mid_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule